// File: doc/BRIEF.md
# Packed Half-Precision to Signed 64-bit Integer Converter

This block turns a vector of IEEE half-precision numbers into signed 64-bit integers, one output lane per 64 bits of the selected vector length (2, 4 or 8 lanes). Each lane normally reads the half-precision element with its own index. A memory-sourced operation with the broadcast bit set feeds element 0 to every lane. The rounding direction comes from a global mode field. A per-operation rounding field replaces it only for a register source at the full vector length with the broadcast/rounding bit set.

Each active lane can be gated by a write mask. A gated lane either keeps the previous destination contents (merging) or is cleared (zeroing). Everything above the vector length is cleared. One invalid flag and one precision flag go with each result. Both are gathered only from lanes that were actually written. The result, its flags and a valid strobe appear one clock after an input strobe and hold until the next one.

Top module: `hp2q_vec_cvt`

## Requirements
- R1: `vl_code` selects the lane count: 00 gives 2 lanes, 01 gives 4, and 10 or 11 give 8. Every destination bit above 64 times the lane count reads zero.
- R2: Lane j converts source bits [16j+15:16j]. When `src_mem` and `bcst_rc` are both 1, every lane converts bits [15:0] instead.
- R3: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. `rc_static` is used only when `src_mem`=0, `bcst_rc`=1 and the lane count is 8. In every other case `rc_global` is used.
- R4: A finite input becomes its value rounded to an integer by the selected mode, as a two's-complement 64-bit number. The precision flag rises when any fractional part was discarded.
- R5: An input with exponent field 11111 (infinity or NaN) gives 0x8000000000000000 in its lane and raises the invalid flag, without raising precision.
- R6: With `mask_en`=1 and `kmask[j]`=0, active lane j becomes zero if `zero_sel`=1 and keeps `dst_prev` lane j if `zero_sel`=0. With `mask_en`=0, every active lane is written.
- R7: Each flag output is the OR of that flag over the lanes that were written. Masked-off lanes and lanes beyond the vector length contribute nothing.
- R8: `dst`, the flags and `out_valid` update on the clock edge after `in_valid`=1. While `in_valid`=0, `out_valid` falls and `dst` and the flags hold.
- R9: After reset, `dst` is zero and `out_valid`, `flag_inv` and `flag_inx` are 0.
- R10: Subnormal inputs give 0 under nearest-even and toward-zero rounding, and give +1 (positive, rounding up) or -1 (negative, rounding down) under the directed modes. Precision is raised for every nonzero subnormal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| vl_code | input | 2 | Vector length code |
| src_mem | input | 1 | 1 = source operand came from memory |
| bcst_rc | input | 1 | Broadcast (memory) or static-rounding (register) bit |
| rc_static | input | 2 | Per-operation rounding mode |
| rc_global | input | 2 | Global rounding mode |
| mask_en | input | 1 | Write masking enabled |
| kmask | input | 8 | Per-lane write mask |
| zero_sel | input | 1 | 1 = zero masked lanes, 0 = merge |
| src | input | 128 | Packed half-precision source |
| dst_prev | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result strobe |
| dst | output | 512 | Converted destination |
| flag_inv | output | 1 | Invalid flag of the last result |
| flag_inx | output | 1 | Precision flag of the last result |

## Verification
The bench builds the block with its default parameters: 8 lanes at most, 2 lanes at least, 16-bit elements and 64-bit integers. These settings reach all four vector-length codes, including the one that saturates at 8 lanes, so the rounding override can be tested both at full length and below it. With 16-bit elements, the bench can cover every exponent class: zero, subnormal, tie cases, the ±65504 extremes, infinities and NaN. A model computed with real arithmetic supplies the expected lanes and flags to a scoreboard.

// File: rtl/hp2q_pkg.sv
package hp2q_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;

   typedef struct packed {
      logic inv;
      logic inx;
   } lane_flags_t;
endpackage

// File: rtl/hp2q_mode_sel.sv
module hp2q_mode_sel
   import hp2q_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int MIN_LANES = 2,
   parameter int VL_W      = 2
) (
   input  logic [VL_W-1:0]  vl_code,
   input  logic             src_mem,
   input  logic             bcst_rc,
   input  logic [1:0]       rc_static,
   input  logic [1:0]       rc_global,
   output rmode_e           mode,
   output logic             bcast,
   output logic [LANES-1:0] lane_on
);
   localparam int CNT_W = $clog2(LANES + 1) + VL_W + 1;

   logic [CNT_W-1:0] raw_cnt;
   logic [CNT_W-1:0] n_lanes;
   logic             full_len;

   always_comb begin
      raw_cnt  = CNT_W'(MIN_LANES) << vl_code;
      n_lanes  = (raw_cnt > CNT_W'(LANES)) ? CNT_W'(LANES) : raw_cnt;
      full_len = (n_lanes == CNT_W'(LANES));
      bcast    = src_mem & bcst_rc;
      if (!src_mem && bcst_rc && full_len)
         mode = rmode_e'(rc_static);
      else
         mode = rmode_e'(rc_global);
   end

   for (genvar j = 0; j < LANES; j++) begin : g_on
      assign lane_on[j] = (CNT_W'(j) < n_lanes);
   end
endmodule

// File: rtl/hp2q_lane_cvt.sv
module hp2q_lane_cvt
   import hp2q_pkg::*;
#(
   parameter int FP_W  = 16,
   parameter int EXP_W = 5,
   parameter int INT_W = 64
) (
   input  logic [FP_W-1:0]  h,
   input  rmode_e           mode,
   output logic [INT_W-1:0] q,
   output lane_flags_t      fl
);
   localparam int MAN_W   = FP_W - 1 - EXP_W;
   localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
   localparam int FRAC_SH = BIAS + MAN_W;
   localparam int SH_MAX  = FRAC_SH - 1;
   localparam int LSH_MAX = (1 << EXP_W) - 2 - FRAC_SH;
   localparam int MAG_W   = MAN_W + 2 + LSH_MAX;
   localparam int EXT_W   = MAN_W + 1 + SH_MAX;

   logic             sgn;
   logic [EXP_W-1:0] ex;
   logic [MAN_W-1:0] mn;
   logic [EXP_W-1:0] ex_eff;
   logic [MAN_W:0]   sig;
   logic [EXP_W:0]   lsh, rsh;
   logic             big;
   logic [EXT_W-1:0] ext;
   logic [MAN_W:0]   ipart;
   logic [SH_MAX-1:0] frac;
   logic             grd, stk, inexact, bump;
   logic [MAG_W-1:0] mag;
   logic [INT_W-1:0] magx;

   always_comb begin
      sgn    = h[FP_W-1];
      ex     = h[FP_W-2 -: EXP_W];
      mn     = h[MAN_W-1:0];
      ex_eff = (ex == '0) ? EXP_W'(1) : ex;
      sig    = {(ex != '0), mn};
      lsh    = {1'b0, ex_eff} - (EXP_W+1)'(FRAC_SH);
      rsh    = (EXP_W+1)'(FRAC_SH) - {1'b0, ex_eff};
      big    = ({1'b0, ex_eff} >= (EXP_W+1)'(FRAC_SH));
      ext    = big ? '0 : ({sig, {SH_MAX{1'b0}}} >> rsh);
      ipart  = ext[EXT_W-1 -: (MAN_W+1)];
      frac   = ext[SH_MAX-1:0];
      grd    = frac[SH_MAX-1];
      stk    = |frac[SH_MAX-2:0];
      inexact = |frac;
      unique case (mode)
         RM_NEAR: bump = grd & (stk | ipart[0]);
         RM_DOWN: bump = sgn & inexact;
         RM_UP:   bump = ~sgn & inexact;
         default: bump = 1'b0;
      endcase
      if (big)
         mag = MAG_W'(sig) << lsh;
      else
         mag = MAG_W'(ipart) + MAG_W'(bump);
      magx = INT_W'(mag);
      if (ex == '1) begin
         q      = {1'b1, {(INT_W-1){1'b0}}};
         fl.inv = 1'b1;
         fl.inx = 1'b0;
      end else begin
         q      = sgn ? (~magx + INT_W'(1)) : magx;
         fl.inv = 1'b0;
         fl.inx = inexact;
      end
   end
endmodule

// File: rtl/hp2q_lane_wr.sv
module hp2q_lane_wr
   import hp2q_pkg::*;
#(
   parameter int INT_W = 64
) (
   input  logic             on,
   input  logic             mask_en,
   input  logic             kbit,
   input  logic             zero_sel,
   input  logic [INT_W-1:0] cvt,
   input  lane_flags_t      cvt_fl,
   input  logic [INT_W-1:0] prev,
   output logic [INT_W-1:0] lane,
   output lane_flags_t      lane_fl
);
   logic wr;

   always_comb begin
      wr = on & (~mask_en | kbit);
      if (!on)
         lane = '0;
      else if (wr)
         lane = cvt;
      else if (zero_sel)
         lane = '0;
      else
         lane = prev;
      lane_fl.inv = wr & cvt_fl.inv;
      lane_fl.inx = wr & cvt_fl.inx;
   end
endmodule

// File: rtl/hp2q_vec_cvt.sv
module hp2q_vec_cvt
   import hp2q_pkg::*;
#(
   parameter int LANES     = 8,
   parameter int MIN_LANES = 2,
   parameter int VL_W      = 2,
   parameter int FP_W      = 16,
   parameter int EXP_W     = 5,
   parameter int INT_W     = 64,
   localparam int SRC_W    = LANES * FP_W,
   localparam int DST_W    = LANES * INT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VL_W-1:0]  vl_code,
   input  logic             src_mem,
   input  logic             bcst_rc,
   input  logic [1:0]       rc_static,
   input  logic [1:0]       rc_global,
   input  logic             mask_en,
   input  logic [LANES-1:0] kmask,
   input  logic             zero_sel,
   input  logic [SRC_W-1:0] src,
   input  logic [DST_W-1:0] dst_prev,
   output logic             out_valid,
   output logic [DST_W-1:0] dst,
   output logic             flag_inv,
   output logic             flag_inx
);
   if (FP_W - 1 - EXP_W < 2) begin : g_bad_man
      $error("hp2q_vec_cvt: mantissa too narrow");
   end
   if (INT_W < FP_W + 4) begin : g_bad_int
      $error("hp2q_vec_cvt: INT_W too small for the finite range");
   end
   if (MIN_LANES < 1 || (MIN_LANES << ((1 << VL_W) - 1)) < LANES) begin : g_bad_lanes
      $error("hp2q_vec_cvt: LANES unreachable from vl_code");
   end

   rmode_e           mode;
   logic             bcast;
   logic [LANES-1:0] lane_on;
   logic [DST_W-1:0] dst_nxt;
   logic [LANES-1:0] inv_v, inx_v;

   hp2q_mode_sel #(.LANES(LANES), .MIN_LANES(MIN_LANES), .VL_W(VL_W)) u_mode (
      .vl_code(vl_code), .src_mem(src_mem), .bcst_rc(bcst_rc),
      .rc_static(rc_static), .rc_global(rc_global),
      .mode(mode), .bcast(bcast), .lane_on(lane_on)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [FP_W-1:0]  elem;
      logic [INT_W-1:0] cvt;
      lane_flags_t      cfl, wfl;

      assign elem = bcast ? src[FP_W-1:0] : src[j*FP_W +: FP_W];

      hp2q_lane_cvt #(.FP_W(FP_W), .EXP_W(EXP_W), .INT_W(INT_W)) u_cvt (
         .h(elem), .mode(mode), .q(cvt), .fl(cfl)
      );

      hp2q_lane_wr #(.INT_W(INT_W)) u_wr (
         .on(lane_on[j]), .mask_en(mask_en), .kbit(kmask[j]), .zero_sel(zero_sel),
         .cvt(cvt), .cvt_fl(cfl), .prev(dst_prev[j*INT_W +: INT_W]),
         .lane(dst_nxt[j*INT_W +: INT_W]), .lane_fl(wfl)
      );

      assign inv_v[j] = wfl.inv;
      assign inx_v[j] = wfl.inx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst       <= '0;
         flag_inv  <= 1'b0;
         flag_inx  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dst      <= dst_nxt;
            flag_inv <= |inv_v;
            flag_inx <= |inx_v;
         end
      end
   end
endmodule

// File: rtl/hp2q_vec_cvt_chk.sv
module hp2q_vec_cvt_chk #(
   parameter int LANES = 8,
   parameter int SRC_W = 128,
   parameter int DST_W = 512,
   parameter int INT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       vl_code,
   input logic             src_mem,
   input logic             mask_en,
   input logic [LANES-1:0] kmask,
   input logic             zero_sel,
   input logic [SRC_W-1:0] src,
   input logic [DST_W-1:0] dst_prev,
   input logic             out_valid,
   input logic [DST_W-1:0] dst,
   input logic             flag_inv,
   input logic             flag_inx
);
   // R8
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(dst) && $stable(flag_inv) && $stable(flag_inx)));
   // R1
   short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vl_code == 2'b00) |=> (dst[DST_W-1:2*INT_W] == '0));
   // R6
   merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !kmask[0] && !zero_sel) |=> (dst[INT_W-1:0] == $past(dst_prev[INT_W-1:0])));
   // R6
   zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && !kmask[0] && zero_sel) |=> (dst[INT_W-1:0] == '0));
   // R7
   masked_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_en && kmask == '0) |=> (!flag_inv && !flag_inx));
   // R5
   finite_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && vl_code == 2'b00 && !src_mem && src[14:10] != 5'h1f && src[30:26] != 5'h1f) |=> !flag_inv);
endmodule

bind hp2q_vec_cvt hp2q_vec_cvt_chk #(.LANES(LANES), .SRC_W(SRC_W), .DST_W(DST_W), .INT_W(INT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vl_code(vl_code), .src_mem(src_mem),
   .mask_en(mask_en), .kmask(kmask), .zero_sel(zero_sel), .src(src), .dst_prev(dst_prev),
   .out_valid(out_valid), .dst(dst), .flag_inv(flag_inv), .flag_inx(flag_inx)
);

// File: tb/sim_hp2q_vec_cvt.sv
module sim_hp2q_vec_cvt;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   vl_code = '0;
   logic         src_mem = 1'b0, bcst_rc = 1'b0;
   logic [1:0]   rc_static = '0, rc_global = '0;
   logic         mask_en = 1'b0, zero_sel = 1'b0;
   logic [7:0]   kmask = '0;
   logic [127:0] src = '0;
   logic [511:0] dst_prev = '0;
   logic         out_valid, flag_inv, flag_inx;
   logic [511:0] dst;

   int n_cmp = 0, n_bad = 0;
   logic [511:0] exp_dst_q[$];
   logic [1:0]   exp_fl_q[$];
   string        tag_q[$];
   logic [511:0] last_dst;
   logic [1:0]   last_fl;

   always #5 clk = ~clk;

   hp2q_vec_cvt u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vl_code(vl_code), .src_mem(src_mem),
      .bcst_rc(bcst_rc), .rc_static(rc_static), .rc_global(rc_global), .mask_en(mask_en),
      .kmask(kmask), .zero_sel(zero_sel), .src(src), .dst_prev(dst_prev),
      .out_valid(out_valid), .dst(dst), .flag_inv(flag_inv), .flag_inx(flag_inx)
   );

   // reference conversion through real arithmetic
   task automatic ref_cvt(input logic [15:0] h, input logic [1:0] rm,
                          output logic [63:0] r, output logic inv, output logic inx);
      real x, fl, fr, y;
      int  e, m;
      e = int'(h[14:10]);
      m = int'(h[9:0]);
      inv = 1'b0; inx = 1'b0;
      if (e == 31) begin
         inv = 1'b1; r = 64'h8000_0000_0000_0000;
         return;
      end
      if (e == 0) x = real'(m) * (2.0 ** -24);
      else        x = real'(1024 + m) * (2.0 ** (e - 25));
      if (h[15]) x = -x;
      fl = $floor(x);
      fr = x - fl;
      inx = (fr != 0.0);
      case (rm)
         2'b00: begin
            if (fr > 0.5) y = fl + 1.0;
            else if (fr < 0.5) y = fl;
            else y = ($rtoi(fl) % 2 == 0) ? fl : fl + 1.0;
         end
         2'b01: y = fl;
         2'b10: y = (fr != 0.0) ? fl + 1.0 : fl;
         default: y = (x < 0.0 && fr != 0.0) ? fl + 1.0 : fl;
      endcase
      r = 64'($rtoi(y));
   endtask

   task automatic drive(input logic [1:0] vl, input logic mem, input logic bc,
                        input logic [1:0] rcs, input logic [1:0] rcg,
                        input logic men, input logic [7:0] k, input logic zm,
                        input logic [127:0] s, input logic [511:0] prev, input string tag);
      logic [511:0] ed;
      logic         ei, ex, li, lx;
      logic [63:0]  lr;
      logic [1:0]   rm;
      int           nl;
      nl = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
      rm = (!mem && bc && nl == 8) ? rcs : rcg;
      ed = '0; ei = 1'b0; ex = 1'b0;
      for (int j = 0; j < 8; j++) begin
         if (j < nl) begin
            if (!men || k[j]) begin
               ref_cvt((mem && bc) ? s[15:0] : s[j*16 +: 16], rm, lr, li, lx);
               ed[j*64 +: 64] = lr;
               ei |= li; ex |= lx;
            end else if (!zm) begin
               ed[j*64 +: 64] = prev[j*64 +: 64];
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b1; vl_code = vl; src_mem = mem; bcst_rc = bc;
      rc_static = rcs; rc_global = rcg; mask_en = men; kmask = k; zero_sel = zm;
      src = s; dst_prev = prev;
      exp_dst_q.push_back(ed);
      exp_fl_q.push_back({ei, ex});
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_dst_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R8 unexpected out_valid: got 1 exp 0");
         end else begin
            logic [511:0] ed;
            logic [1:0]   ef;
            string        t;
            ed = exp_dst_q.pop_front();
            ef = exp_fl_q.pop_front();
            t  = tag_q.pop_front();
            n_cmp++;
            if (dst !== ed || {flag_inv, flag_inx} !== ef) begin
               n_bad++;
               $display("FAIL %s: dst=%h flags=%b exp dst=%h flags=%b", t, dst, {flag_inv, flag_inx}, ed, ef);
            end
            last_dst = ed; last_fl = ef;
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   logic [511:0] prev_pat;
   logic [31:0]  lfsr;

   initial begin
      for (int j = 0; j < 16; j++) prev_pat[j*32 +: 32] = 32'hA5A5_0000 + 32'(j);

      // R9 reset state
      repeat (2) @(negedge clk);
      n_cmp++;
      if (dst !== '0 || out_valid !== 1'b0 || flag_inv !== 1'b0 || flag_inx !== 1'b0) begin
         n_bad++;
         $display("FAIL R9 reset: dst=%h v=%b i=%b x=%b exp all zero", dst, out_valid, flag_inv, flag_inx);
      end
      rst_n = 1'b1;

      // R1 R4: two lanes, upper lanes hold NaN that must not show
      drive(2'b00, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0,
            {16'h7E00, 16'h7C00, 16'hC100, 16'h3C00}, prev_pat, "R1 R4 vl128");
      // R4 ties under nearest-even, four lanes
      drive(2'b01, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0,
            {64'h0, 16'hB800, 16'h4100, 16'h3E00, 16'h3800}, prev_pat, "R4 ties nearest-even");
      // R4 toward zero and up
      drive(2'b01, 0, 0, 2'b00, 2'b11, 0, 8'h00, 0,
            {64'h0, 16'hBE00, 16'h4100, 16'h3E00, 16'hC2CD}, prev_pat, "R4 toward zero");
      drive(2'b01, 0, 0, 2'b00, 2'b10, 0, 8'h00, 0,
            {64'h0, 16'hBE00, 16'h4100, 16'h3E00, 16'h4000}, prev_pat, "R4 toward plus");
      // R3 static override, register source at full length
      drive(2'b10, 0, 1, 2'b01, 2'b00, 0, 8'h00, 0,
            {80'h0, 16'h4100, 16'hBE00, 16'h3E00}, prev_pat, "R3 static override full length");
      // R3 override ignored below full length
      drive(2'b01, 0, 1, 2'b01, 2'b00, 0, 8'h00, 0,
            {80'h0, 16'h4100, 16'hBE00, 16'h3E00}, prev_pat, "R3 no override at 4 lanes");
      // R2 broadcast from memory, global rounding
      drive(2'b10, 1, 1, 2'b01, 2'b10, 0, 8'h00, 0,
            {112'h0, 16'h3E00}, prev_pat, "R2 broadcast element 0");
      // R2 memory source without broadcast
      drive(2'b11, 1, 0, 2'b00, 2'b00, 0, 8'h00, 0,
            {16'h4800, 16'hC800, 16'h5640, 16'h0000, 16'h8000, 16'h7BFF, 16'hFBFF, 16'h3555},
            prev_pat, "R2 R1 per-element code 11");
      // R5 specials and extremes
      drive(2'b10, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0,
            {16'h7BFF, 16'hFBFF, 16'hFC00, 16'h7C00, 16'h7E00, 16'hFE01, 16'h3C00, 16'h0000},
            prev_pat, "R5 infinity NaN");
      // R6 merge
      drive(2'b10, 0, 0, 2'b00, 2'b00, 1, 8'b1010_0110, 0,
            {16'h4A00, 16'hCA00, 16'h3C00, 16'hBC00, 16'h4400, 16'hC400, 16'h3E00, 16'h3800},
            prev_pat, "R6 merge");
      // R6 zeroing
      drive(2'b10, 0, 0, 2'b00, 2'b00, 1, 8'b0101_1001, 1,
            {16'h4A00, 16'hCA00, 16'h3C00, 16'hBC00, 16'h4400, 16'hC400, 16'h3E00, 16'h3800},
            prev_pat, "R6 zeroing");
      // R7 masked NaN and inexact lanes raise nothing
      drive(2'b10, 0, 0, 2'b00, 2'b00, 1, 8'b0000_0001, 0,
            {16'h7E00, 16'h3E00, 16'h7C00, 16'h3555, 16'hFC00, 16'h3800, 16'h7E00, 16'h4000},
            prev_pat, "R7 masked flags");
      // R7 NaN beyond the vector length
      drive(2'b00, 0, 0, 2'b00, 2'b00, 0, 8'h00, 0,
            {16'h7E00, 16'h7E00, 16'h3555, 16'h7C00, 16'h4400, 16'h4000}, prev_pat, "R7 R1 beyond length");
      // R10 subnormals under each mode
      for (int rm = 0; rm < 4; rm++)
         drive(2'b01, 0, 0, 2'b00, 2'(rm), 0, 8'h00, 0,
               {64'h0, 16'h83FF, 16'h0200, 16'h8001, 16'h0001}, prev_pat, "R10 subnormal");
      idle();

      // R8 hold during idle
      repeat (3) @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0 || dst !== last_dst || {flag_inv, flag_inx} !== last_fl) begin
         n_bad++;
         $display("FAIL R8 hold: v=%b dst=%h fl=%b exp v=0 dst=%h fl=%b",
                  out_valid, dst, {flag_inv, flag_inx}, last_dst, last_fl);
      end

      // R4 R6 R3 mixed pseudo-random traffic
      lfsr = 32'h1D87_2B41;
      for (int n = 0; n < 40; n++) begin
         logic [127:0] s;
         for (int j = 0; j < 4; j++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s[j*32 +: 32] = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         end
         drive(lfsr[1:0], lfsr[2], lfsr[3], lfsr[5:4], lfsr[7:6], lfsr[8], lfsr[16:9], lfsr[17],
               s, {prev_pat[255:0], prev_pat[511:256]}, "R4 R6 random");
         if (lfsr[20]) idle();
      end
      idle();
      repeat (4) @(negedge clk);
      if (exp_dst_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R8 missing results: got %0d pending exp 0", exp_dst_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule